// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

The fetch stage uses this block to choose the next instruction address. Each cycle it receives the current fetch PC and looks in a small direct-mapped table. The table index comes from a few low PC bits. A redirect happens only when the entry is valid, the entry holds exactly the same branch PC, and the entry's 2-bit saturating counter leans toward taken. In that case the predicted next PC is the stored target and the taken flag is raised. In every other case the next PC is the sequential address PC+4. Both results appear one clock after the PC is presented.

Decode drives a second, independent port once it has resolved a branch. That port carries the branch PC, the real outcome and the computed target. If the addressed entry already belongs to that PC, its counter takes one saturating step and its target is rewritten. If the entry is empty or belongs to another PC, the entry is claimed for the new branch, with a weak counter state that matches the outcome. The hysteresis of the counter means an occasional opposite outcome does not flip a well-established prediction.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every entry. While reset is held, and after it is released until an entry is written, every lookup returns PC+4 with the taken flag low.
- R2: An address maps to table entry PC[2 +: log2(ENTRIES)]. The two byte-offset bits and the bits above the index do not take part in indexing.
- R3: A lookup predicts taken when the indexed entry is valid, its stored PC equals the lookup PC, and its counter's upper bit is 1. The next PC is then the stored target and the taken flag is high. Both results are valid in the cycle after the PC is presented.
- R4: When the conditions of R3 do not all hold, the next PC is the lookup PC plus 4 and the taken flag is low, one cycle after the PC is presented.
- R5: Counter codes are 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. An update that claims an entry sets the code to 10 for a taken outcome and 01 for a not-taken outcome.
- R6: An update whose PC matches the valid stored PC moves the counter one step up for a taken outcome and one step down for a not-taken outcome, saturating at 11 and 00. The same update replaces the stored target with the supplied one.
- R7: A counter in a strong state keeps its predicted direction after one opposite outcome and changes it only after a second consecutive opposite outcome.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup result reflects the contents from before that update.
- R9: A lookup of a PC that shares an index with a different stored PC never redirects. An update from such a PC replaces the entry, and the entry then belongs to the new PC only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_next_pc | output | PC_W | Predicted next fetch PC, one cycle after lk_pc |
| lk_taken | output | 1 | High when lk_next_pc is a predicted branch target |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | PC_W | Computed target of the resolved branch |

## Verification
The assertions assume that the lookup PC is a known value in every cycle, including the reset cycles, because the fall-through check compares against the PC from the previous cycle. They also assume that the update inputs are known whenever the update strobe is high. The stimulus drives only word-aligned addresses taken from a small pool, and it holds the lookup PC defined from time zero. The pool holds pairs of addresses that share an index, so aliasing and replacement happen often. The stimulus also deliberately aims lookups at the entry being updated in the same cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // 2-bit direction counter; the upper bit is the predicted direction
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

endpackage

// File: rtl/btb_pc_hash.sv
module btb_pc_hash #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);

  // word-aligned instruction addresses: skip the byte-offset bits
  localparam int OFS_W = 2;

  assign idx = pc[OFS_W +: IDX_W];

  logic unused_hash_bits;
  assign unused_hash_bits = ^{pc[OFS_W-1:0], pc[PC_W-1:OFS_W+IDX_W]};

endmodule

// File: rtl/btb_dir_ctr.sv
module btb_dir_ctr
  import btb_pkg::*;
(
  input  ctr_e cur,
  input  logic owned,
  input  logic taken,
  output ctr_e nxt
);

  always_comb begin
    if (!owned) begin
      nxt = taken ? CTR_WT : CTR_WNT;
    end else begin
      unique case (cur)
        CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
        CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
        CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
        default: nxt = taken ? CTR_ST  : CTR_WT;
      endcase
    end
  end

endmodule

// File: rtl/btb_target_ram.sv
module btb_target_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, read-first: a same-address write is not seen this cycle
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/btb_meta_array.sv
module btb_meta_array
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [PC_W-1:0]  rd_pc,
  output logic             rd_redirect,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic             wr_taken
);

  logic [ENTRIES-1:0] vld_q;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  ctr_e               ctr_q [ENTRIES];

  logic wr_hit;
  ctr_e wr_ctr_nxt;

  assign rd_redirect = vld_q[rd_idx] && (tag_q[rd_idx] == rd_pc) && ctr_q[rd_idx][1];
  assign wr_hit      = vld_q[wr_idx] && (tag_q[wr_idx] == wr_pc);

  btb_dir_ctr u_ctr (
    .cur   (ctr_q[wr_idx]),
    .owned (wr_hit),
    .taken (wr_taken),
    .nxt   (wr_ctr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_pc;
      ctr_q[wr_idx] <= wr_ctr_nxt;
    end
  end

  AST_ALLOC_WEAK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hit) |=> ctr_q[$past(wr_idx)] == ($past(wr_taken) ? CTR_WT : CTR_WNT)); // R5

  AST_STRONG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit && ctr_q[wr_idx] == CTR_ST && !wr_taken) |=> ctr_q[$past(wr_idx)] == CTR_WT); // R7

  AST_STRONG_NT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit && ctr_q[wr_idx] == CTR_SNT && wr_taken) |=> ctr_q[$past(wr_idx)] == CTR_WNT); // R7

  AST_OWNER_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_pc)); // R9

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic [PC_W-1:0] lk_next_pc,
  output logic            lk_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic             lk_redirect_c;
  logic             hit_q;
  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  tgt_q;

  btb_pc_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash_lk (
    .pc  (lk_pc),
    .idx (lk_idx)
  );

  btb_pc_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash_upd (
    .pc  (upd_pc),
    .idx (upd_idx)
  );

  btb_meta_array #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_meta (
    .clk         (clk),
    .rst         (rst),
    .rd_idx      (lk_idx),
    .rd_pc       (lk_pc),
    .rd_redirect (lk_redirect_c),
    .wr_en       (upd_valid),
    .wr_idx      (upd_idx),
    .wr_pc       (upd_pc),
    .wr_taken    (upd_taken)
  );

  btb_target_ram #(.DATA_W(PC_W), .DEPTH(ENTRIES)) u_tgt (
    .clk   (clk),
    .we    (upd_valid),
    .waddr (upd_idx),
    .wdata (upd_target),
    .raddr (lk_idx),
    .rdata (tgt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= lk_redirect_c;
    end
    pc_q <= lk_pc;
  end

  assign lk_next_pc = hit_q ? tgt_q : (pc_q + STEP);
  assign lk_taken   = hit_q;

  AST_RESET_NO_REDIRECT: assert property (@(posedge clk)
    rst |=> !lk_taken); // R1

  AST_FALLTHROUGH_SEQ: assert property (@(posedge clk) disable iff (rst)
    !lk_taken |-> lk_next_pc == $past(lk_pc) + STEP); // R4

endmodule

// File: tb/btb_predictor_tb_top.sv
module btb_predictor_tb_top;

  localparam int PC_W    = 32;
  localparam int ENTRIES = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] lk_pc = 32'h100;
  logic [PC_W-1:0] lk_next_pc;
  logic            lk_taken;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;
  logic [PC_W-1:0] upd_target = '0;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model of the table
  bit             m_vld [ENTRIES];
  logic [31:0]    m_tag [ENTRIES];
  logic [31:0]    m_tgt [ENTRIES];
  logic [1:0]     m_ctr [ENTRIES];

  logic [31:0] got_pc;
  logic        got_tk;

  always #2 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .lk_pc      (lk_pc),
    .lk_next_pc (lk_next_pc),
    .lk_taken   (lk_taken),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_target (upd_target)
  );

  // R2: index from PC bits [5:2] for 16 entries
  function automatic int m_idx(logic [31:0] pc);
    return int'(pc[5:2]);
  endfunction

  function automatic logic m_pred(logic [31:0] pc);
    int i = m_idx(pc);
    return m_vld[i] && m_tag[i] == pc && m_ctr[i][1];
  endfunction

  function automatic logic [31:0] m_next(logic [31:0] pc);
    return m_pred(pc) ? m_tgt[m_idx(pc)] : pc + 32'd4;
  endfunction

  function automatic logic [1:0] m_step(logic [1:0] c, bit t);
    if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
    return (c == 2'b00) ? 2'b00 : c - 2'd1;
  endfunction

  task automatic m_update(logic [31:0] pc, bit t, logic [31:0] tg);
    int i = m_idx(pc);
    if (m_vld[i] && m_tag[i] == pc) begin
      m_ctr[i] = m_step(m_ctr[i], t);
    end else begin
      m_ctr[i] = t ? 2'b10 : 2'b01;
      m_tag[i] = pc;
      m_vld[i] = 1'b1;
    end
    m_tgt[i] = tg;
  endtask

  task automatic m_clear();
    for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
  endtask

  task automatic chk(string req, logic [31:0] gp, logic gt, logic [31:0] ep, logic et);
    n_chk++;
    if (gp !== ep || gt !== et) begin
      n_fail++;
      $display("FAIL %s: got next=%h taken=%0b expected next=%h taken=%0b", req, gp, gt, ep, et);
    end
  endtask

  // one cycle: drive at negedge, sample at the following negedge, check vs model
  task automatic cyc(logic [31:0] lpc, bit uv, logic [31:0] upc, bit ut,
                     logic [31:0] utg, string req);
    logic [31:0] ep;
    logic        et;
    lk_pc      = lpc;
    upd_valid  = uv;
    upd_pc     = upc;
    upd_taken  = ut;
    upd_target = utg;
    ep = m_next(lpc);
    et = m_pred(lpc);
    @(posedge clk);
    @(negedge clk);
    got_pc = lk_next_pc;
    got_tk = lk_taken;
    chk(req, got_pc, got_tk, ep, et);
    if (uv) m_update(upc, ut, utg);
    upd_valid = 1'b0;
  endtask

  task automatic look(logic [31:0] lpc, string req);
    cyc(lpc, 1'b0, 32'h0, 1'b0, 32'h0, req);
  endtask

  task automatic upd(logic [31:0] pc, bit t, logic [31:0] tg, string req);
    cyc(32'h0000_0F00, 1'b1, pc, t, tg, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    lk_pc = 32'h100;
    upd_valid = 1'b0;
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 during reset", lk_next_pc, lk_taken, 32'h104, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  localparam logic [31:0] PA = 32'h0000_2000;
  localparam logic [31:0] PB = 32'h0000_2040; // same index as PA
  localparam logic [31:0] PC = 32'h0000_2004;

  initial begin
    void'($urandom(32'd20240611));
    m_clear();
    do_reset();

    // R1: empty table after reset
    look(PA, "R1");
    chk("R1 explicit", got_pc, got_tk, PA + 32'd4, 1'b0);

    // R8: lookup and update on same entry in the same cycle see old contents
    cyc(PA, 1'b1, PA, 1'b1, 32'h3000, "R8");
    chk("R8 explicit", got_pc, got_tk, PA + 32'd4, 1'b0);

    // R5/R3: claimed with weakly taken, redirects
    look(PA, "R3");
    chk("R5 alloc taken", got_pc, got_tk, 32'h3000, 1'b1);

    // R9/R2: alias with same index but different PC does not hit
    look(PB, "R9");
    chk("R9 alias", got_pc, got_tk, PB + 32'd4, 1'b0);

    // R6: one not-taken step 10 -> 01, no redirect
    upd(PA, 1'b0, 32'h3000, "R6");
    look(PA, "R6");
    chk("R6 step down", got_pc, got_tk, PA + 32'd4, 1'b0);

    // R6: climb to strongly taken
    upd(PA, 1'b1, 32'h3000, "R6");
    upd(PA, 1'b1, 32'h3000, "R6");
    look(PA, "R6");
    chk("R6 step up", got_pc, got_tk, 32'h3000, 1'b1);
    upd(PA, 1'b1, 32'h3000, "R6");

    // R7: one opposite outcome keeps direction, the second flips it
    upd(PA, 1'b0, 32'h3000, "R7");
    look(PA, "R7");
    chk("R7 first miss holds", got_pc, got_tk, 32'h3000, 1'b1);
    upd(PA, 1'b0, 32'h3000, "R7");
    look(PA, "R7");
    chk("R7 second miss flips", got_pc, got_tk, PA + 32'd4, 1'b0);

    // R7: strongly not taken needs two taken outcomes
    upd(PA, 1'b0, 32'h3000, "R7");
    upd(PA, 1'b1, 32'h3000, "R7");
    look(PA, "R7");
    chk("R7 snt first taken holds", got_pc, got_tk, PA + 32'd4, 1'b0);
    upd(PA, 1'b1, 32'h3000, "R7");
    look(PA, "R7");
    chk("R7 snt second taken flips", got_pc, got_tk, 32'h3000, 1'b1);

    // R5: claimed not taken starts weakly not taken
    upd(PC, 1'b0, 32'h5000, "R5");
    look(PC, "R5");
    chk("R5 alloc not taken", got_pc, got_tk, PC + 32'd4, 1'b0);
    upd(PC, 1'b1, 32'h5000, "R5");
    look(PC, "R5");
    chk("R5 weak moves in one", got_pc, got_tk, 32'h5000, 1'b1);

    // R9: alias replaces the entry
    upd(PB, 1'b1, 32'h6000, "R9");
    look(PB, "R9");
    chk("R9 new owner", got_pc, got_tk, 32'h6000, 1'b1);
    look(PA, "R9");
    chk("R9 old owner gone", got_pc, got_tk, PA + 32'd4, 1'b0);

    // R6: target refreshed on a matching update
    upd(PB, 1'b1, 32'h7000, "R6");
    look(PB, "R6");
    chk("R6 target refresh", got_pc, got_tk, 32'h7000, 1'b1);

    // random phase over a pool with aliases
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] lp, up, tg;
      bit uv, ut;
      string rq;
      lp = 32'h0000_1000 + 32'(($urandom % 10) * 4) + (($urandom % 2) ? 32'h40 : 32'h0);
      up = ($urandom % 3 == 0) ? lp :
           32'h0000_1000 + 32'(($urandom % 10) * 4) + (($urandom % 2) ? 32'h40 : 32'h0);
      uv = ($urandom % 10) < 6;
      ut = ($urandom % 4) != 0;
      tg = {16'h0, 14'($urandom), 2'b00};
      if (uv && m_idx(up) == m_idx(lp)) rq = "R8";
      else if (m_pred(lp)) rq = "R3";
      else rq = "R4";
      cyc(lp, uv, up, ut, tg, rq);
    end

    // R1: reset forgets trained entries
    look(PB, "R3");
    do_reset();
    look(PB, "R1");
    chk("R1 after retrain", got_pc, got_tk, PB + 32'd4, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule